// File: doc/BRIEF.md
# I2C Master Two-Level Interrupt Hub

This block gathers the event pulses and FIFO service levels of an I2C master engine into a per-event master status register. Each master status bit is masked by a master enable register. Any master bit that is both set and enabled raises the master bit of a small top-level status register. The top level also holds a slave bit, which a separate slave event input sets. A top-level enable register then decides which of those two bits drive the single interrupt line.

Software reaches every register through a simple word-addressed write strobe and a combinational read port. Event bits stay set until software writes a one to them. The two FIFO service bits follow their input levels directly. A global control register holds three mode enables (master, slave, bus-management timing). A soft-reset register clears all status and enable state. Its bit reads as one for as long as the reset runs.

Top module: `i2c_irq_hub`

## Requirements
- R1: After `rst_n` is released, every register (addresses 0 to 5) reads zero and `irq` is low. Unmapped addresses 6 and 7 always read zero.
- R2: A pulse on `mst_evt` bit k, for k from 4 to 11, sets bit k of the master status register (address 3) at the next rising edge. The bit stays set until it is cleared. Bits 3:0 of that register always read zero, whatever `mst_evt[3:0]` does.
- R3: Writing address 3 clears each event bit (11:4) whose `reg_wdata` bit is one and leaves the others unchanged. If a new event arrives in the same cycle as the clearing write, the bit stays set.
- R4: Bits 12 (TX FIFO service) and 13 (RX FIFO service) of address 3 show `mst_evt[12]` and `mst_evt[13]` in the same cycle, with no latching. Writes to address 3 have no effect on them.
- R5: The master enable register (address 4) reads back bits 13:0 exactly as last written. Bits 31:14 read zero.
- R6: At the rising edge after a cycle in which some address-3 bit and the same bit of address 4 are both one, bit 0 (master) of the top-level status register (address 1) becomes one. Master status bits that are disabled never set it.
- R7: Writing one to bit 0 of address 1 clears the master bit. If an enabled master status bit is still set in that cycle, the master bit stays one.
- R8: A pulse on `slv_evt` sets bit 1 (slave) of address 1 at the next edge. Writing one to bit 1 of address 1 clears it, unless `slv_evt` is high in the same cycle.
- R9: `irq` is one exactly when some bit of address 1 is set together with the same bit of the top-level enable register (address 2, bits 1:0). It follows those registers in the same cycle.
- R10: The global control register (address 0) keeps bits 2:0 (bit 0 master enable, bit 1 slave enable, bit 2 bus-management timing) exactly as written, and its other bits read zero. Soft reset does not change it.
- R11: Writing one to bit 0 of address 5 starts a soft reset. For the next `RST_CYC` cycles, address 5 reads 1. At the start edge and throughout that window, addresses 1 to 4 are held at zero, and events and writes to them are ignored. After the window, address 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| mst_evt | input | 14 | Master event pulses (11:4) and FIFO service levels (13:12) |
| slv_evt | input | 1 | Slave interrupt event pulse |
| irq | output | 1 | Interrupt line |

## Verification
A master event pulse appears on the read port at address 3 in the first cycle after the edge that samples it. The top-level master bit follows one edge later, so it is visible two cycles after the pulse. The FIFO service bits and `irq` respond within the same cycle as their inputs or register changes. The soft-reset busy bit reads one for exactly `RST_CYC` reads that follow the start write. The bench drives each cycle's stimulus on the falling edge and samples 1 ns later, before the next rising edge. A requirement-level model is advanced on every rising edge, so each expected value refers to the state of the correct cycle.

// File: rtl/irqh_pkg.sv
`timescale 1ns/1ps
package irqh_pkg;
   localparam int MST_W   = 14;
   localparam int EVT_LO  = 4;
   localparam logic [MST_W-1:0] LIVE_MASK = 14'h3000;
   localparam int A_CTRL  = 0;
   localparam int A_TSTAT = 1;
   localparam int A_TEN   = 2;
   localparam int A_MSTAT = 3;
   localparam int A_MEN   = 4;
   localparam int A_SRST  = 5;
   localparam int TOP_MST = 0;
   localparam int TOP_SLV = 1;
   localparam int CTRL_W  = 3;
endpackage

// File: rtl/irqh_leaf.sv
`timescale 1ns/1ps
module irqh_leaf
   import irqh_pkg::*;
#(
   parameter int W  = MST_W,
   parameter int LO = EVT_LO,
   parameter logic [W-1:0] LIVE = LIVE_MASK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic         clr_we,
   input  logic         en_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] evt,
   output logic [W-1:0] stat,
   output logic [W-1:0] en,
   output logic         any
);
   if (LO >= W) begin : g_bad_lo
      $error("irqh_leaf: LO must be below W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= '0;
      else if (srst)   en <= '0;
      else if (en_we)  en <= wdata;
   end

   assign any = |(stat & en);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < LO) begin : g_none
         logic unused_evt;
         assign unused_evt = evt[i];
         assign stat[i] = 1'b0;
      end else if (LIVE[i]) begin : g_live
         assign stat[i] = evt[i] & ~srst;
      end else begin : g_sticky
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= 1'b0;
            else if (srst) q <= 1'b0;
            else           q <= (q & ~(clr_we & wdata[i])) | evt[i];
         end
         assign stat[i] = q;

         p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !srst) |=> stat[i]);
         p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !(clr_we && wdata[i]) && !srst) |=> stat[i]);
         p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wdata[i] && !evt[i]) |=> !stat[i]);
      end
   end

   p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_we && !srst) |=> $stable(en));
endmodule

// File: rtl/irqh_root.sv
`timescale 1ns/1ps
module irqh_root
   import irqh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       srst,
   input  logic       mst_any,
   input  logic       slv_evt,
   input  logic       clr_we,
   input  logic       en_we,
   input  logic [1:0] wdata,
   output logic [1:0] st,
   output logic [1:0] en,
   output logic       irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
         en <= '0;
      end else if (srst) begin
         st <= '0;
         en <= '0;
      end else begin
         st[TOP_MST] <= (st[TOP_MST] & ~(clr_we & wdata[TOP_MST])) | mst_any;
         st[TOP_SLV] <= (st[TOP_SLV] & ~(clr_we & wdata[TOP_SLV])) | slv_evt;
         if (en_we) en <= wdata;
      end
   end

   assign irq = |(st & en);

   p_top_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_any && !srst) |=> st[TOP_MST]);
   p_slv_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wdata[TOP_SLV] && !slv_evt && !srst) |=> !st[TOP_SLV]);
   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en == 2'b00) |-> !irq);
endmodule

// File: rtl/irqh_srst.sv
`timescale 1ns/1ps
module irqh_srst #(
   parameter int RST_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(RST_CYC + 1);

   if (RST_CYC < 1) begin : g_bad_cyc
      $error("irqh_srst: RST_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (start)     cnt <= CW'(RST_CYC);
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   p_busy_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   p_busy_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt == CW'(1) && !start) |=> !busy);
endmodule

// File: rtl/i2c_irq_hub.sv
`timescale 1ns/1ps
module i2c_irq_hub
   import irqh_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter int RST_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [MST_W-1:0]  mst_evt,
   input  logic              slv_evt,
   output logic              irq
);
   if (DATA_W < MST_W) begin : g_bad_data
      $error("i2c_irq_hub: DATA_W too narrow for master status");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("i2c_irq_hub: ADDR_W must be at least 3");
   end

   logic              hit_ctrl, hit_tstat, hit_ten, hit_mstat, hit_men, hit_srst;
   logic              srst_start, srst_busy, srst;
   logic [CTRL_W-1:0] ctrl_q;
   logic [MST_W-1:0]  mst_stat, mst_en;
   logic              mst_any;
   logic [1:0]        top_st, top_en;
   logic              unused_wdata;

   assign hit_ctrl  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign hit_tstat = reg_wr && (reg_addr == ADDR_W'(A_TSTAT));
   assign hit_ten   = reg_wr && (reg_addr == ADDR_W'(A_TEN));
   assign hit_mstat = reg_wr && (reg_addr == ADDR_W'(A_MSTAT));
   assign hit_men   = reg_wr && (reg_addr == ADDR_W'(A_MEN));
   assign hit_srst  = reg_wr && (reg_addr == ADDR_W'(A_SRST));

   assign srst_start = hit_srst && reg_wdata[0];
   assign srst       = srst_start || srst_busy;
   assign unused_wdata = ^reg_wdata[DATA_W-1:MST_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (hit_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
   end

   irqh_srst #(.RST_CYC(RST_CYC)) u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (srst_busy)
   );

   irqh_leaf #(.W(MST_W), .LO(EVT_LO), .LIVE(LIVE_MASK)) u_leaf (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .clr_we (hit_mstat),
      .en_we  (hit_men),
      .wdata  (reg_wdata[MST_W-1:0]),
      .evt    (mst_evt),
      .stat   (mst_stat),
      .en     (mst_en),
      .any    (mst_any)
   );

   irqh_root u_root (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .mst_any (mst_any),
      .slv_evt (slv_evt),
      .clr_we  (hit_tstat),
      .en_we   (hit_ten),
      .wdata   (reg_wdata[1:0]),
      .st      (top_st),
      .en      (top_en),
      .irq     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CTRL))       reg_rdata = DATA_W'(ctrl_q);
      else if (reg_addr == ADDR_W'(A_TSTAT)) reg_rdata = DATA_W'(top_st);
      else if (reg_addr == ADDR_W'(A_TEN))   reg_rdata = DATA_W'(top_en);
      else if (reg_addr == ADDR_W'(A_MSTAT)) reg_rdata = DATA_W'(mst_stat);
      else if (reg_addr == ADDR_W'(A_MEN))   reg_rdata = DATA_W'(mst_en);
      else if (reg_addr == ADDR_W'(A_SRST))  reg_rdata = DATA_W'(srst_busy);
   end

   p_srst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> (mst_en == '0 && top_en == '0 && top_st == '0));
   p_ctrl_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_ctrl |=> $stable(ctrl_q));
endmodule

// File: tb/i2c_irq_hub_tb.sv
`timescale 1ns/1ps
module i2c_irq_hub_tb;
   localparam int RST_CYC = 4;
   localparam logic [13:0] LIVE   = 14'h3000;
   localparam logic [13:0] STICKY = 14'h0FF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [13:0] mst_evt = '0;
   logic        slv_evt = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;

   logic [2:0]  m_ctrl;
   logic [1:0]  m_top, m_ten;
   logic [13:0] m_st, m_men;
   int          m_cnt;

   always #10 clk = ~clk;

   i2c_irq_hub #(.DATA_W(32), .ADDR_W(3), .RST_CYC(RST_CYC)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mst_evt   (mst_evt),
      .slv_evt   (slv_evt),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [2:0] a, input logic [13:0] e);
      logic busy;
      busy = (m_cnt > 0);
      case (a)
         3'd0: exp_rd = {29'b0, m_ctrl};
         3'd1: exp_rd = {30'b0, m_top};
         3'd2: exp_rd = {30'b0, m_ten};
         3'd3: exp_rd = busy ? 32'b0 : {18'b0, m_st | (e & LIVE)};
         3'd4: exp_rd = {18'b0, m_men};
         3'd5: exp_rd = {31'b0, busy};
         default: exp_rd = 32'b0;
      endcase
   endfunction

   task automatic step(input logic [13:0] e, input logic s, input logic w,
                       input logic [2:0] a, input logic [31:0] d);
      logic start, clr, any;
      start = w && a == 3'd5 && d[0];
      clr = start || (m_cnt > 0);
      if (w && a == 3'd0) m_ctrl = d[2:0];
      if (clr) begin
         m_top = '0; m_ten = '0; m_st = '0; m_men = '0;
      end else begin
         any = |((m_st | (e & LIVE)) & m_men);
         m_top[0] = (m_top[0] & ~(w && a == 3'd1 && d[0])) | any;
         m_top[1] = (m_top[1] & ~(w && a == 3'd1 && d[1])) | s;
         m_st = (m_st & ~((w && a == 3'd3) ? d[13:0] : 14'h0)) | (e & STICKY);
         if (w && a == 3'd4) m_men = d[13:0];
         if (w && a == 3'd2) m_ten = d[1:0];
      end
      if (start) m_cnt = RST_CYC;
      else if (m_cnt > 0) m_cnt--;
   endtask

   task automatic cyc(input logic [13:0] e, input logic s, input logic w,
                      input logic [2:0] a, input logic [31:0] d, input string tag);
      @(negedge clk);
      mst_evt = e; slv_evt = s; reg_wr = w; reg_addr = a; reg_wdata = d;
      #1;
      if (!w) check(tag, reg_rdata, exp_rd(a, e));
      check({tag, " R9 irq"}, {31'b0, irq}, {31'b0, |(m_top & m_ten)});
      @(posedge clk);
      step(e, s, w, a, d);
   endtask

   task automatic rd(input logic [2:0] a, input logic [13:0] e, input string tag);
      cyc(e, 1'b0, 1'b0, a, 32'h0, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
      cyc(14'h0, 1'b0, 1'b1, a, d, tag);
   endtask

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: tag_of = "R10 ctrl";
         3'd1: tag_of = "R6/R7/R8 top status";
         3'd2: tag_of = "R9 top enable";
         3'd3: tag_of = "R2/R3/R4 master status";
         3'd4: tag_of = "R5 master enable";
         3'd5: tag_of = "R11 soft reset";
         default: tag_of = "R1 unmapped";
      endcase
   endfunction

   initial begin : wd
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_ctrl = '0; m_top = '0; m_ten = '0; m_st = '0; m_men = '0; m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         @(negedge clk); reg_addr = 3'(a); #1;
         check("R1 reset read", reg_rdata, 32'h0);
      end
      check("R1 reset irq", {31'b0, irq}, 32'h0);

      // R5 readback of master enable
      wr(3'd4, 32'hFFFF_FFFF, "R5");
      @(negedge clk); reg_wr = 0; reg_addr = 3'd4; #1;
      check("R5 all ones", reg_rdata, 32'h0000_3FFF);
      wr(3'd4, 32'h0000_2A5A, "R5");
      rd(3'd4, 14'h0, "R5 pattern");
      wr(3'd4, 32'h0, "R5");

      // R2 sticky event, low bits ignored
      cyc(14'h004F, 1'b0, 1'b0, 3'd3, 0, "R2 pulse");
      rd(3'd3, 14'h0, "R2 set");
      @(negedge clk); reg_addr = 3'd3; #1;
      check("R2 literal", reg_rdata, 32'h0000_0040);
      rd(3'd3, 14'h0, "R2 held");

      // R3 write-one clear, write-zero keep, event beats clear
      wr(3'd3, 32'h0, "R3");
      rd(3'd3, 14'h0, "R3 zero write keeps");
      cyc(14'h0040, 1'b0, 1'b1, 3'd3, 32'h40, "R3 clear vs event");
      rd(3'd3, 14'h0, "R3 event wins");
      wr(3'd3, 32'hFFFF_FFFF, "R3");
      rd(3'd3, 14'h0, "R3 cleared");

      // R4 live FIFO service bits
      rd(3'd3, 14'h1000, "R4 tx level");
      cyc(14'h3000, 1'b0, 1'b1, 3'd3, 32'h3000, "R4 write ignored");
      rd(3'd3, 14'h3000, "R4 both levels");
      @(negedge clk); mst_evt = 14'h2000; reg_addr = 3'd3; #1;
      check("R4 literal", reg_rdata, 32'h0000_2000);
      @(posedge clk); step(14'h2000, 0, 0, 3'd3, 0);
      rd(3'd3, 14'h0, "R4 level gone");

      // R6 top master set, masked bits ignored
      wr(3'd2, 32'h3, "R9");
      cyc(14'h0100, 1'b0, 1'b0, 3'd1, 0, "R6 disabled event");
      rd(3'd1, 14'h0, "R6 masked");
      rd(3'd1, 14'h0, "R6 masked stays low");
      wr(3'd4, 32'h0000_0080, "R6");
      cyc(14'h0080, 1'b0, 1'b0, 3'd1, 0, "R6 enabled event");
      rd(3'd1, 14'h0, "R6 one cycle");
      rd(3'd1, 14'h0, "R6 two cycles");

      // R7 top clear while leaf still set, then real clear
      wr(3'd1, 32'h1, "R7 clear with leaf set");
      rd(3'd1, 14'h0, "R7 re-armed");
      wr(3'd3, 32'h0000_0080, "R7");
      wr(3'd1, 32'h1, "R7");
      rd(3'd1, 14'h0, "R7 cleared");

      // R8 slave bit
      cyc(14'h0, 1'b1, 1'b0, 3'd1, 0, "R8 pulse");
      rd(3'd1, 14'h0, "R8 set");
      cyc(14'h0, 1'b1, 1'b1, 3'd1, 32'h2, "R8 clear vs pulse");
      rd(3'd1, 14'h0, "R8 pulse wins");
      wr(3'd1, 32'h2, "R8");
      rd(3'd1, 14'h0, "R8 cleared");

      // R9 enable gating
      cyc(14'h0, 1'b1, 1'b0, 3'd2, 0, "R9");
      wr(3'd2, 32'h0, "R9 disable");
      rd(3'd2, 14'h0, "R9 irq low");
      wr(3'd2, 32'h2, "R9 slave only");
      rd(3'd2, 14'h0, "R9 irq high");

      // R10 control
      wr(3'd0, 32'hFFFF_FFFD, "R10");
      @(negedge clk); reg_wr = 0; reg_addr = 3'd0; #1;
      check("R10 literal", reg_rdata, 32'h0000_0005);

      // R11 soft reset window
      wr(3'd4, 32'h3FF0, "R11");
      wr(3'd5, 32'h1, "R11 start");
      for (int k = 0; k < RST_CYC; k++) begin
         @(negedge clk); reg_wr = 0; reg_addr = 3'd5; mst_evt = 14'h0FF0; slv_evt = 1; #1;
         check("R11 busy", reg_rdata, 32'h1);
         @(posedge clk); step(14'h0FF0, 1'b1, 1'b0, 3'd5, 0);
      end
      rd(3'd5, 14'h0, "R11 done");
      rd(3'd3, 14'h0, "R11 status cleared");
      rd(3'd4, 14'h0, "R11 enable cleared");
      rd(3'd1, 14'h0, "R11 top cleared");
      rd(3'd0, 14'h0, "R10 kept over soft reset");

      // random phase
      begin
         logic [13:0] lvl;
         lvl = '0;
         for (int n = 0; n < 4000; n++) begin
            logic [13:0] e;
            logic        s, w;
            logic [2:0]  a;
            logic [31:0] d;
            if ($urandom_range(0, 15) == 0) lvl = 14'($urandom) & LIVE;
            e = (14'($urandom) & 14'($urandom) & 14'($urandom) & 14'h0FFF) | lvl;
            s = ($urandom_range(0, 7) == 0);
            w = ($urandom_range(0, 2) == 0);
            a = 3'($urandom_range(0, 7));
            d = $urandom;
            if (w && a == 3'd5 && $urandom_range(0, 7) != 0) d[0] = 1'b0;
            cyc(e, s, w, a, d, tag_of(a));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule